// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block takes level-sensitive interrupt requests from a fixed set of sources and picks, each cycle, the one that the CPU should take. Sources are arranged in groups of equal size. Each group stands for one pin or peripheral module and has one programmable 4-bit priority level. Sources inside a group share that level and are ranked by a fixed order. When groups tie on level, a fixed default order decides between them.

The highest-ranked request is accepted only if its level is strictly above the CPU's current mask level. On acceptance the controller emits a one-cycle pulse carrying three values: a unique vector number for the source, the byte offset of that vector's 32-bit table entry, and the level that the CPU loads into its mask bits. Software sets the priorities through a small write port of 16-bit registers, each holding four level fields.

Top module: `intc_vectored`

## Requirements
- R1: After reset every group level is 0, `accept_o` is low and `vector_o`, `vec_offset_o` and `new_level_o` are 0. While all levels are 0, no request is accepted for any mask value.
- R2: A write with `wr_en_i` high to address a stores `wr_data_i` in register a. Register a holds the levels of groups 4a to 4a+3, and group g uses bits [4*(g mod 4)+3 : 4*(g mod 4)]. A write to an address at or above NUM_GROUPS/4 changes no level.
- R3: A source is accepted only if its group level is strictly greater than `mask_i`. A level equal to or below the mask, and in particular level 0, is never accepted.
- R4: Among requesting sources, the one whose group level is highest wins.
- R5: Source index s belongs to group s / SRCS_PER_GROUP, at slot s mod SRCS_PER_GROUP. Within one group, the requesting source with the lowest slot wins.
- R6: When requesting sources in different groups have the same highest level, the source in the lowest-numbered group wins.
- R7: On acceptance, `vector_o` equals VEC_BASE (default 64) plus the winner's source index, and `vec_offset_o` equals `vector_o` times 4.
- R8: On acceptance, `new_level_o` equals the winner's group level.
- R9: The controller samples requests, mask and levels at a clock edge and presents the result one cycle later. `accept_o` is never high in two consecutive cycles; the cycle after an accept, nothing is accepted.
- R10: While `accept_o` is low, `vector_o`, `vec_offset_o` and `new_level_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Priority register write enable |
| wr_addr_i | input | ADDR_W (3) | Priority register address |
| wr_data_i | input | 16 | Four 4-bit group levels |
| req_i | input | NUM_GROUPS*SRCS_PER_GROUP (32) | Level-sensitive requests, bit s is source s |
| mask_i | input | 4 | CPU's current mask level |
| accept_o | output | 1 | One-cycle accept pulse |
| vector_o | output | VEC_W (8) | Vector number of the accepted source |
| vec_offset_o | output | VEC_W+2 (10) | Byte offset of the vector table entry |
| new_level_o | output | 4 | Level to load into the CPU mask bits |

## Verification
The bench goes after a level exactly equal to the mask: a design using greater-or-equal would accept there and produce a pulse the model does not expect. It pits two slots of one group, and two groups on the same level, against each other; a reversed scan or a tie rule that lets the later source win would show up as the wrong vector. It holds a request steady across cycles to catch a design that raises accept on back-to-back cycles. It writes to an out-of-range address to catch a decoder that wraps and overwrites a real register. Random levels, masks and sparse request patterns then compare every cycle against a bench model of the ranking.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int PRIO_W         = 4;
    localparam int REG_W          = 16;
    localparam int FIELDS_PER_REG = REG_W / PRIO_W;

    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/intc_prio_regs.sv
module intc_prio_regs
    import intc_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int ADDR_W     = 3
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [REG_W-1:0]             wr_data_i,
    output prio_t [NUM_GROUPS-1:0]       level_o
);
    localparam int NUM_REGS = (NUM_GROUPS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;

    logic [REG_W-1:0] regs_d [NUM_REGS];
    logic [REG_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            regs_d[r] = regs_q[r];
            if (wr_en_i && (int'(wr_addr_i) == r)) begin
                regs_d[r] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        for (int r = 0; r < NUM_REGS; r++) begin
            if (!rst_ni) regs_q[r] <= '0;
            else         regs_q[r] <= regs_d[r];
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_field
        localparam int REG_IDX = g / FIELDS_PER_REG;
        localparam int LSB     = PRIO_W * (g % FIELDS_PER_REG);
        assign level_o[g] = regs_q[REG_IDX][LSB +: PRIO_W];
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
        AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && int'(wr_addr_i) == r) |=> (regs_q[r] == $past(wr_data_i))) // R2
            else $error("priority write lost");
        AST_NO_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(wr_en_i && int'(wr_addr_i) == r) |=> $stable(regs_q[r])) // R2
            else $error("priority register changed without a write");
    end
endmodule

// File: rtl/intc_group_pick.sv
module intc_group_pick #(
    parameter int SRCS   = 4,
    parameter int SLOT_W = (SRCS > 1) ? $clog2(SRCS) : 1
) (
    input  logic [SRCS-1:0]   req_i,
    output logic              valid_o,
    output logic [SLOT_W-1:0] slot_o
);
    logic [SRCS-1:0] grant;
    logic            found;

    always_comb begin
        grant  = '0;
        slot_o = '0;
        found  = 1'b0;
        for (int i = 0; i < SRCS; i++) begin
            if (req_i[i] && !found) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                slot_o   = SLOT_W'(i);
            end
        end
    end

    assign valid_o = |req_i;

    always_comb begin
        AST_ONE_GRANT: assert ($onehot0(grant) && ((|grant) == valid_o)) // R5
            else $error("group grant not one-hot");
    end
endmodule

// File: rtl/intc_level_select.sv
module intc_level_select
    import intc_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int SLOT_W     = 2,
    parameter int SRC_W      = 5
) (
    input  logic [NUM_GROUPS-1:0]  grp_valid_i,
    input  prio_t [NUM_GROUPS-1:0] grp_level_i,
    input  logic [SLOT_W-1:0]      grp_slot_i [NUM_GROUPS],
    output logic                   win_valid_o,
    output prio_t                  win_level_o,
    output logic [SRC_W-1:0]       win_src_o
);
    localparam int GRP_W = SRC_W - SLOT_W;

    always_comb begin
        win_valid_o = 1'b0;
        win_level_o = '0;
        win_src_o   = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_valid_i[g] && (!win_valid_o || grp_level_i[g] > win_level_o)) begin
                win_valid_o = 1'b1;
                win_level_o = grp_level_i[g];
                win_src_o   = {GRP_W'(g), grp_slot_i[g]};
            end
        end
    end

    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            AST_WINNER_MAX: assert (!(grp_valid_i[g] && win_valid_o) || grp_level_i[g] <= win_level_o) // R4
                else $error("winner below a requesting group");
        end
    end
endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
    import intc_pkg::*;
#(
    parameter int NUM_GROUPS     = 8,
    parameter int SRCS_PER_GROUP = 4,
    parameter int ADDR_W         = 3,
    parameter int VEC_BASE       = 64,
    parameter int VEC_W          = 8,
    localparam int NUM_SRC       = NUM_GROUPS * SRCS_PER_GROUP,
    localparam int OFF_W         = VEC_W + 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [PRIO_W-1:0]  mask_i,
    output logic               accept_o,
    output logic [VEC_W-1:0]   vector_o,
    output logic [OFF_W-1:0]   vec_offset_o,
    output logic [PRIO_W-1:0]  new_level_o
);
    localparam int SLOT_W = (SRCS_PER_GROUP > 1) ? $clog2(SRCS_PER_GROUP) : 1;
    localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int SRC_W  = SLOT_W + GRP_W;

    typedef struct packed {
        logic              acc;
        logic [VEC_W-1:0]  vec;
        logic [OFF_W-1:0]  off;
        prio_t             lvl;
    } out_t;

    prio_t [NUM_GROUPS-1:0] grp_level;
    logic  [NUM_GROUPS-1:0] grp_valid;
    logic  [SLOT_W-1:0]     grp_slot [NUM_GROUPS];
    logic                   win_valid;
    prio_t                  win_level;
    logic  [SRC_W-1:0]      win_src;
    out_t                   st_d, st_q;

    intc_prio_regs #(
        .NUM_GROUPS(NUM_GROUPS),
        .ADDR_W    (ADDR_W)
    ) i_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .level_o  (grp_level)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        intc_group_pick #(
            .SRCS  (SRCS_PER_GROUP),
            .SLOT_W(SLOT_W)
        ) i_pick (
            .req_i  (req_i[g*SRCS_PER_GROUP +: SRCS_PER_GROUP]),
            .valid_o(grp_valid[g]),
            .slot_o (grp_slot[g])
        );
    end

    intc_level_select #(
        .NUM_GROUPS(NUM_GROUPS),
        .SLOT_W    (SLOT_W),
        .SRC_W     (SRC_W)
    ) i_sel (
        .grp_valid_i(grp_valid),
        .grp_level_i(grp_level),
        .grp_slot_i (grp_slot),
        .win_valid_o(win_valid),
        .win_level_o(win_level),
        .win_src_o  (win_src)
    );

    always_comb begin
        logic [VEC_W-1:0] vec;
        vec  = VEC_W'(VEC_BASE) + VEC_W'(win_src);
        st_d = '0;
        if (win_valid && (win_level > mask_i) && !st_q.acc) begin
            st_d.acc = 1'b1;
            st_d.vec = vec;
            st_d.off = {vec, 2'b00};
            st_d.lvl = win_level;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign accept_o     = st_q.acc;
    assign vector_o     = st_q.vec;
    assign vec_offset_o = st_q.off;
    assign new_level_o  = st_q.lvl;

    AST_ACCEPT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |=> !accept_o) // R9
        else $error("accept held two cycles");
    AST_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> (new_level_o > $past(mask_i))) // R3
        else $error("accepted at or below mask");
    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !accept_o |-> (vector_o == '0 && vec_offset_o == '0 && new_level_o == '0)) // R10
        else $error("outputs not zero while idle");
    AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> (int'(vector_o) >= VEC_BASE && int'(vector_o) < VEC_BASE + NUM_SRC)) // R7
        else $error("vector out of range");
endmodule

// File: tb/test_intc_vectored.sv
module test_intc_vectored;
    localparam int NG = 8;
    localparam int SPG = 4;
    localparam int NS = NG * SPG;
    localparam int VB = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [NS-1:0] req;
    logic [3:0]  mask;
    logic        accept;
    logic [7:0]  vector;
    logic [9:0]  vec_off;
    logic [3:0]  new_lvl;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [3:0] prio_m [NG];
    logic       exp_acc;
    logic [7:0] exp_vec;
    logic [9:0] exp_off;
    logic [3:0] exp_lvl;
    string      exp_tag;

    always #10 clk = ~clk;

    intc_vectored i_intc_vectored (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .req_i       (req),
        .mask_i      (mask),
        .accept_o    (accept),
        .vector_o    (vector),
        .vec_offset_o(vec_off),
        .new_level_o (new_lvl)
    );

    task automatic check(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic compare_outputs();
        check({exp_tag, " R9"}, "accept", int'(accept), int'(exp_acc));
        check({exp_tag, " R7"}, "vector", int'(vector), int'(exp_vec));
        check({exp_tag, " R7"}, "offset", int'(vec_off), int'(exp_off));
        check({exp_tag, " R8"}, "level", int'(new_lvl), int'(exp_lvl));
    endtask

    // one cycle: check previous result, drive new inputs, predict the next result
    task automatic step(input string tag, input logic [NS-1:0] r, input logic [3:0] m,
                        input logic we, input logic [2:0] a, input logic [15:0] d);
        bit found = 1'b0;
        int best_s = 0;
        logic [3:0] best_l = '0;
        logic nacc;
        @(negedge clk);
        compare_outputs();
        req = r; mask = m; wr_en = we; wr_addr = a; wr_data = d;
        for (int s = 0; s < NS; s++) begin
            if (r[s] && (!found || prio_m[s / SPG] > best_l)) begin
                found = 1'b1;
                best_l = prio_m[s / SPG];
                best_s = s;
            end
        end
        nacc = found && (best_l > m) && !exp_acc;
        exp_acc = nacc;
        exp_vec = nacc ? 8'(VB + best_s) : 8'd0;
        exp_off = nacc ? 10'((VB + best_s) * 4) : 10'd0;
        exp_lvl = nacc ? best_l : 4'd0;
        exp_tag = tag;
        if (we && a < 3'(NG / 4)) begin
            for (int f = 0; f < 4; f++) prio_m[a * 4 + f] = d[f*4 +: 4];
        end
    endtask

    task automatic wr(input string tag, input logic [2:0] a, input logic [15:0] d);
        step(tag, '0, 4'd0, 1'b1, a, d);
    endtask

    task automatic idle(input string tag);
        step(tag, '0, 4'd0, 1'b0, 3'd0, 16'd0);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                failures++;
                $display("FAIL watchdog expired");
                done = 1'b1;
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; req = '0; mask = '0;
        for (int g = 0; g < NG; g++) prio_m[g] = 4'd0;
        exp_acc = 1'b0; exp_vec = '0; exp_off = '0; exp_lvl = '0; exp_tag = "R1 reset";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset outputs and zero levels never accepted
        check("R1", "reset accept", int'(accept), 0);
        check("R10", "reset vector", int'(vector), 0);
        step("R1 all-zero levels", '1, 4'd0, 1'b0, 3'd0, 16'd0);
        step("R1 all-zero levels", '1, 4'd0, 1'b0, 3'd0, 16'd0);
        idle("R1");
        // R2: field layout; group 6 gets level 5 via register 1 bits [11:8]
        wr("R2 write", 3'd1, 16'h0500);
        step("R2 field layout", NS'(1) << 25, 4'd4, 1'b0, 3'd0, 16'd0);
        idle("R2");
        // R2: out-of-range write must not alter group 0 or group 6
        wr("R2 stray write", 3'd5, 16'hFFFF);
        step("R2 stray write ignored", (NS'(1) << 1) | (NS'(1) << 24), 4'd0, 1'b0, 3'd0, 16'd0);
        idle("R2");
        // R3: level equal to mask is refused, one above is taken
        wr("R3 setup", 3'd0, 16'h0007);
        step("R3 level equals mask", NS'(1) << 2, 4'd7, 1'b0, 3'd0, 16'd0);
        step("R3 level above mask", NS'(1) << 2, 4'd6, 1'b0, 3'd0, 16'd0);
        idle("R3");
        // R5: two slots of one group, lowest slot wins
        step("R5 slot ranking", (NS'(1) << 3) | (NS'(1) << 1), 4'd0, 1'b0, 3'd0, 16'd0);
        idle("R5");
        // R6: groups 1 and 5 tie at level 9, group 1 wins
        wr("R6 setup", 3'd0, 16'h0090);
        wr("R6 setup", 3'd1, 16'h0090);
        step("R6 tie across groups", (NS'(1) << 20) | (NS'(1) << 6), 4'd0, 1'b0, 3'd0, 16'd0);
        idle("R6");
        // R4: higher level in a later group beats an earlier group
        wr("R4 setup", 3'd1, 16'hF090);
        step("R4 highest level", (NS'(1) << 4) | (NS'(1) << 31), 4'd14, 1'b0, 3'd0, 16'd0);
        idle("R4");
        // R9: steady request gives accept, gap, accept
        for (int k = 0; k < 4; k++)
            step("R9 holdoff", NS'(1) << 29, 4'd3, 1'b0, 3'd0, 16'd0);
        idle("R9");
        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [NS-1:0] r;
            logic we;
            r = NS'($urandom) & NS'($urandom) & NS'($urandom);
            we = ($urandom % 8) == 0;
            step("R4 R5 R6 random", r, 4'($urandom), we, 3'($urandom % 3), 16'($urandom));
        end
        idle("R10 final");
        idle("R10 final");
        @(negedge clk);
        compare_outputs();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule